// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns a stream of 24-bit audio samples into a serial data line, one bit per bit clock, with a frame-sync (LR) line alongside. One engine covers six frame styles: single-channel, single-channel with a one-bit lag, two-channel PCM, I2S, and time-division multiplexed frames of one to eight slots, with or without the one-bit lag. Samples come from an upstream sample FIFO over a ready/valid handshake. The block takes exactly one sample at the start of every slot.

As clock master, the block divides the system clock by an even number to make the bit clock, and builds the frame-sync waveform itself. As clock slave, it synchronises an external bit clock and frame sync into the system clock domain, finds the start of each frame from the frame-sync edge, and shifts in step with the external clock. Polarity inversion can be set separately for the master outputs and for the slave inputs.

Each slot is 32 bit-clock periods wide. The sample occupies the first 24 bits, MSB first, and the last 8 bits are zero. A 16-bit source is expected to arrive already left-justified in the 24-bit word. If the FIFO has nothing to give when a slot begins, the slot is sent as zeros and a sticky underrun flag is raised.

Top module: `audio_ser_tx`

## Requirements
- R1: `fmt_code` selects the frame style: 0 single-channel, 1 single-channel lagged, 2 PCM, 3 I2S, 4 TDM, 5 TDM lagged. A frame holds 1 slot for codes 0/1, 2 slots for codes 2/3, and `tdm_slots_m1`+1 slots for codes 4/5.
- R2: Every slot lasts 32 bit-clock periods. Bits 23 down to 0 of the sample go out first, MSB first, followed by 8 zero bits. Data changes after the falling edge of the normalised bit clock and is valid at the next rising edge.
- R3: For codes 1, 3 and 5, the sample MSB appears one bit period after the frame start. For codes 0, 2 and 4, it appears in the first bit period of the frame.
- R4: The normalised frame sync is a square wave for codes 2/3: low for the 32 bits of slot 0 and high for slot 1. For the other codes it is high only during the first bit period of each frame.
- R5: In master mode (`master_mode`=1), the bit clock spends exactly `div_half` system cycles in each phase. While `clk_en`=0, the bit clock, frame sync and data are held at their idle levels and no sample is requested. The first falling edge after enable begins frame position 0.
- R6: `inv_m_bck` and `inv_m_lr` invert `sck_out` and `lr_out` in master mode. `inv_s_bck` and `inv_s_lr` invert the sense of `sck_in` and `lr_in` in slave mode.
- R7: In slave mode, the block shifts on the falling edges of the synchronised, normalised `sck_in`, and drives `sck_out` and `lr_out` low. A frame starts when the normalised `lr_in` makes the transition that marks position 0 (a fall for codes 2/3, a rise otherwise). No data is sent before the first such transition.
- R8: `s_ready` is high for exactly one system cycle at the start of each slot, and one sample is consumed per slot, in FIFO order.
- R9: If `s_valid` is low while `s_ready` is high, the slot carries zeros and `underrun` rises. `underrun` then stays high until reset.
- R10: While `rst` is high, `sd_out`, `s_ready`, `underrun`, `sck_out` and `lr_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_code | input | 3 | Frame style code |
| tdm_slots_m1 | input | 3 | TDM slot count minus one |
| master_mode | input | 1 | 1: generate clocks, 0: follow external clocks |
| clk_en | input | 1 | Master clock enable; holds the master clock idle when 0 |
| div_half | input | DIV_W | System cycles per bit-clock phase in master mode |
| inv_m_bck | input | 1 | Invert generated bit clock |
| inv_m_lr | input | 1 | Invert generated frame sync |
| inv_s_bck | input | 1 | Invert sense of external bit clock |
| inv_s_lr | input | 1 | Invert sense of external frame sync |
| sck_in | input | 1 | External bit clock (slave mode) |
| lr_in | input | 1 | External frame sync (slave mode) |
| s_data | input | 24 | Sample word from the FIFO |
| s_valid | input | 1 | Sample word available |
| s_ready | output | 1 | Sample taken this cycle |
| sck_out | output | 1 | Generated bit clock |
| lr_out | output | 1 | Generated frame sync |
| sd_out | output | 1 | Serial data |
| underrun | output | 1 | Sticky empty-FIFO flag |

## Verification
The assertions assume that the format code and the inversion controls change only while the engine is idle. They also assume that an external bit clock has each phase longer than the three-flop synchroniser, so falling edges are always at least two system cycles apart. The bench reconfigures only between runs, after a reset and with the master clock disabled. In slave runs it drives an external clock with eight system cycles per phase and changes the frame sync only together with the bit-clock fall.

// File: rtl/atx_pkg.sv
package atx_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int SLOT_BITS  = 32;
    localparam int SLOT_IDX_W = $clog2(SLOT_BITS);
    localparam int MAX_SLOTS  = 8;
    localparam int SLOT_CNT_W = $clog2(MAX_SLOTS);
    localparam int POS_W      = $clog2(SLOT_BITS * MAX_SLOTS);

    typedef enum logic [2:0] {
        FMT_MONO     = 3'd0,
        FMT_MONO_DLY = 3'd1,
        FMT_PCM      = 3'd2,
        FMT_I2S      = 3'd3,
        FMT_TDM      = 3'd4,
        FMT_TDM_DLY  = 3'd5
    } fmt_e;

    typedef struct packed {
        fmt_e                  code;
        logic [SLOT_CNT_W-1:0] slots_m1;
    } fmt_cfg_t;

    // formats whose first data bit lags the frame start by one bit
    function automatic logic is_delayed(input fmt_e c);
        return (c == FMT_MONO_DLY) || (c == FMT_I2S) || (c == FMT_TDM_DLY);
    endfunction

    // formats with a 50 % duty frame sync (one half per channel)
    function automatic logic is_square(input fmt_e c);
        return (c == FMT_PCM) || (c == FMT_I2S);
    endfunction

    // index of the last bit position in a frame
    function automatic logic [POS_W-1:0] last_pos(input fmt_cfg_t f);
        case (f.code)
            FMT_PCM, FMT_I2S:     return POS_W'(2 * SLOT_BITS - 1);
            FMT_TDM, FMT_TDM_DLY: return {f.slots_m1, {SLOT_IDX_W{1'b1}}};
            default:              return POS_W'(SLOT_BITS - 1);
        endcase
    endfunction

endpackage

// File: rtl/atx_clkgen.sv
module atx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master_mode,
    input  logic             clk_en,
    input  logic [DIV_W-1:0] div_half,
    input  logic             sck_in,
    input  logic             lr_in,
    input  logic             inv_s_bck,
    input  logic             inv_s_lr,
    output logic             tick,
    output logic             bck,
    output logic             lr_ext,
    output logic             run
);
    logic [DIV_W-1:0] hcnt;
    logic [DIV_W-1:0] limit;
    logic             bck_q;
    logic             m_run;
    logic             wrap;
    logic [2:0]       sck_sync;
    logic [1:0]       lr_sync;

    assign limit = (div_half == '0) ? '0 : div_half - 1'b1;
    assign m_run = master_mode & clk_en;
    assign wrap  = (hcnt >= limit);

    // master divider: one toggle of the bit clock every div_half cycles
    always_ff @(posedge clk) begin
        if (rst || !m_run) begin
            hcnt  <= '0;
            bck_q <= 1'b0;
        end else if (wrap) begin
            hcnt  <= '0;
            bck_q <= ~bck_q;
        end else begin
            hcnt  <= hcnt + 1'b1;
        end
    end

    // slave inputs: normalise polarity, then synchronise
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sync <= '0;
            lr_sync  <= '0;
        end else begin
            sck_sync <= {sck_sync[1:0], sck_in ^ inv_s_bck};
            lr_sync  <= {lr_sync[0], lr_in ^ inv_s_lr};
        end
    end

    assign tick   = master_mode ? (m_run & wrap & bck_q)
                                : (sck_sync[2] & ~sck_sync[1]);
    assign bck    = bck_q;
    assign lr_ext = lr_sync[1];
    assign run    = master_mode ? clk_en : 1'b1;

endmodule

// File: rtl/atx_framer.sv
module atx_framer
    import atx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     tick,
    input  fmt_cfg_t cfg,
    input  logic     master_mode,
    input  logic     lr_ext,
    output logic     shift,
    output logic     slot_load,
    output logic     lr_q
);
    logic             started;
    logic             started_nxt;
    logic             lr_last;
    logic             sq;
    logic             ext_start;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] last;
    logic [POS_W-1:0] pos_inc;
    logic [POS_W-1:0] pos_nxt;

    assign last      = last_pos(cfg);
    assign sq        = is_square(cfg.code);
    assign pos_inc   = (pos >= last) ? '0 : pos + 1'b1;
    assign ext_start = sq ? (lr_last & ~lr_ext) : (~lr_last & lr_ext);

    always_comb begin
        if (master_mode) begin
            started_nxt = 1'b1;
            pos_nxt     = started ? pos_inc : '0;
        end else begin
            started_nxt = started | ext_start;
            pos_nxt     = ext_start ? '0 : pos_inc;
        end
    end

    assign shift     = tick & started_nxt;
    assign slot_load = shift & (pos_nxt[SLOT_IDX_W-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            started <= 1'b0;
            pos     <= '0;
            lr_last <= 1'b0;
            lr_q    <= 1'b0;
        end else if (tick) begin
            started <= started_nxt;
            pos     <= pos_nxt;
            lr_last <= lr_ext;
            lr_q    <= started_nxt & (sq ? (pos_nxt >= POS_W'(SLOT_BITS))
                                         : (pos_nxt == '0));
        end
    end

endmodule

// File: rtl/atx_shifter.sv
module atx_shifter
    import atx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                shift,
    input  logic                load,
    input  logic                delayed,
    input  logic [SAMPLE_W-1:0] s_data,
    input  logic                s_valid,
    output logic                s_ready,
    output logic                sd,
    output logic                underrun
);
    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] src;
    logic                sd_q;
    logic                sd_d;
    logic                ur_q;

    assign s_ready = load;

    always_comb begin
        if (load) src = s_valid ? s_data : '0;
        else      src = shreg;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            shreg <= '0;
            sd_q  <= 1'b0;
            sd_d  <= 1'b0;
        end else if (shift) begin
            shreg <= src << 1;
            sd_q  <= src[SAMPLE_W-1];
            sd_d  <= sd_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                   ur_q <= 1'b0;
        else if (load && !s_valid) ur_q <= 1'b1;
    end

    assign sd       = delayed ? sd_d : sd_q;
    assign underrun = ur_q;

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
    import atx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            fmt_code,
    input  logic [SLOT_CNT_W-1:0] tdm_slots_m1,
    input  logic                  master_mode,
    input  logic                  clk_en,
    input  logic [DIV_W-1:0]      div_half,
    input  logic                  inv_m_bck,
    input  logic                  inv_m_lr,
    input  logic                  inv_s_bck,
    input  logic                  inv_s_lr,
    input  logic                  sck_in,
    input  logic                  lr_in,
    input  logic [SAMPLE_W-1:0]   s_data,
    input  logic                  s_valid,
    output logic                  s_ready,
    output logic                  sck_out,
    output logic                  lr_out,
    output logic                  sd_out,
    output logic                  underrun
);
    fmt_cfg_t cfg;
    logic     tick;
    logic     bck;
    logic     lr_ext;
    logic     run;
    logic     shift;
    logic     slot_load;
    logic     lr_q;

    assign cfg.code     = fmt_e'(fmt_code);
    assign cfg.slots_m1 = tdm_slots_m1;

    atx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk        (clk),
        .rst        (rst),
        .master_mode(master_mode),
        .clk_en     (clk_en),
        .div_half   (div_half),
        .sck_in     (sck_in),
        .lr_in      (lr_in),
        .inv_s_bck  (inv_s_bck),
        .inv_s_lr   (inv_s_lr),
        .tick       (tick),
        .bck        (bck),
        .lr_ext     (lr_ext),
        .run        (run)
    );

    atx_framer u_framer (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .tick       (tick),
        .cfg        (cfg),
        .master_mode(master_mode),
        .lr_ext     (lr_ext),
        .shift      (shift),
        .slot_load  (slot_load),
        .lr_q       (lr_q)
    );

    atx_shifter u_shifter (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .shift   (shift),
        .load    (slot_load),
        .delayed (is_delayed(cfg.code)),
        .s_data  (s_data),
        .s_valid (s_valid),
        .s_ready (s_ready),
        .sd      (sd_out),
        .underrun(underrun)
    );

    assign sck_out = master_mode ? (bck ^ inv_m_bck) : 1'b0;
    assign lr_out  = master_mode ? (lr_q ^ inv_m_lr) : 1'b0;

endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk
    import atx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                master_mode,
    input logic                clk_en,
    input logic [2:0]          fmt_code,
    input logic [SAMPLE_W-1:0] s_data,
    input logic                s_valid,
    input logic                s_ready,
    input logic                sck_out,
    input logic                lr_out,
    input logic                sd_out,
    input logic                underrun
);
    // R8
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready |=> !s_ready);

    // R9
    underrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (s_ready && !s_valid) |=> underrun);

    // R9
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    // R5
    idle_no_load_chk: assert property (@(posedge clk) disable iff (rst)
        (master_mode && !clk_en) |-> !s_ready);

    // R7
    slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !master_mode |-> (!sck_out && !lr_out));

    // R2
    first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (s_ready && s_valid && !is_delayed(fmt_e'(fmt_code)))
            |=> (sd_out == $past(s_data[SAMPLE_W-1])));

endmodule

bind audio_ser_tx audio_ser_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .master_mode(master_mode),
    .clk_en     (clk_en),
    .fmt_code   (fmt_code),
    .s_data     (s_data),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .sck_out    (sck_out),
    .lr_out     (lr_out),
    .sd_out     (sd_out),
    .underrun   (underrun)
);

// File: tb/audio_ser_tx_bench.sv
module audio_ser_tx_bench;
    import atx_pkg::*;

    localparam int DW = 8;
    localparam int H  = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic [2:0]    fmt_code = '0;
    logic [2:0]    tdm_slots_m1 = '0;
    logic          master_mode = 1'b0;
    logic          clk_en = 1'b0;
    logic [DW-1:0] div_half = 8'd2;
    logic          inv_m_bck = 1'b0, inv_m_lr = 1'b0;
    logic          inv_s_bck = 1'b0, inv_s_lr = 1'b0;
    logic          sck_in = 1'b0, lr_in = 1'b0;
    logic [23:0]   s_data = '0;
    logic          s_valid = 1'b0;
    logic          s_ready, sck_out, lr_out, sd_out, underrun;

    audio_ser_tx #(.DIV_W(DW)) u_audio_ser_tx (
        .clk(clk), .rst(rst), .fmt_code(fmt_code), .tdm_slots_m1(tdm_slots_m1),
        .master_mode(master_mode), .clk_en(clk_en), .div_half(div_half),
        .inv_m_bck(inv_m_bck), .inv_m_lr(inv_m_lr),
        .inv_s_bck(inv_s_bck), .inv_s_lr(inv_s_lr),
        .sck_in(sck_in), .lr_in(lr_in), .s_data(s_data), .s_valid(s_valid),
        .s_ready(s_ready), .sck_out(sck_out), .lr_out(lr_out),
        .sd_out(sd_out), .underrun(underrun)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc   = 0;
    bit          done  = 0;
    logic [23:0] smp[$];
    logic [23:0] src_q[$];
    bit          pend = 0;
    bit          pend_nxt;

    // sample source: a handshake seen before the posedge is retired at the next negedge
    always @(negedge clk) begin
        pend_nxt = s_ready && s_valid;
        if (pend && src_q.size() > 0) void'(src_q.pop_front());
        pend    = pend_nxt;
        s_valid = (src_q.size() > 0);
        s_data  = (src_q.size() > 0) ? src_q[0] : 24'h0;
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    function automatic int flen();
        if (fmt_code == 3'd2 || fmt_code == 3'd3) return 64;
        if (fmt_code == 3'd4 || fmt_code == 3'd5) return (int'(tdm_slots_m1) + 1) * 32;
        return 32;
    endfunction

    function automatic logic ubit(input int p, input int ns);
        int g = p / 32;
        int b = p % 32;
        logic [23:0] d = (g < ns) ? smp[g] : 24'h0;
        return (b < 24) ? d[23-b] : 1'b0;
    endfunction

    function automatic logic ebit(input int p, input int ns);
        bit dly = (fmt_code == 3'd1 || fmt_code == 3'd3 || fmt_code == 3'd5);
        if (!dly) return ubit(p, ns);
        return (p == 0) ? 1'b0 : ubit(p - 1, ns);
    endfunction

    function automatic logic elr(input int p);
        int f = p % flen();
        if (fmt_code == 3'd2 || fmt_code == 3'd3) return (f >= 32);
        return (f == 0);
    endfunction

    task automatic load_samples(input int n, input int seed);
        smp.delete();
        src_q.delete();
        for (int i = 0; i < n; i++) begin
            logic [23:0] v = 24'(seed * 24'h10203 + i * 24'h3C5A7) ^ ((i % 2 == 1) ? 24'h800001 : 24'h000000);
            smp.push_back(v);
            src_q.push_back(v);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clk_en = 1'b0;
        master_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_checks(input string tag, input int ns, input int nbits);
        int slots = (nbits + 31) / 32;
        chk({tag, " R9 underrun flag"}, int'(underrun), (slots > ns) ? 1 : 0);
        chk({tag, " R8 samples left"}, src_q.size(), (ns > slots) ? ns - slots : 0);
    endtask

    task automatic run_master(input string tag, input int code, input int sm1, input int dh,
                              input bit ib, input bit il, input int ns, input int nbits);
        int edges = 0, bits = 0, since = 0, toggles = 0;
        logic prev = 1'b0, cur;
        do_reset();
        fmt_code = 3'(code); tdm_slots_m1 = 3'(sm1);
        inv_m_bck = ib; inv_m_lr = il; div_half = DW'(dh);
        load_samples(ns, code + 7 * dh);
        master_mode = 1'b1;
        @(negedge clk);
        @(negedge clk);
        clk_en = 1'b1;
        while (bits < nbits) begin
            @(negedge clk);
            since++;
            cur = sck_out ^ ib;
            if (cur !== prev) begin
                toggles++;
                if (toggles > 1) chk({tag, " R5 half period"}, since, dh);
                since = 0;
                if (cur == 1'b1) begin
                    if (edges > 0) begin
                        chk({tag, " R2/R3 data bit"}, int'(sd_out), int'(ebit(edges - 1, ns)));
                        chk({tag, " R4/R6/R1 frame sync"}, int'(lr_out ^ il), int'(elr(edges - 1)));
                        bits++;
                    end
                    edges++;
                end
            end
            prev = cur;
        end
        end_checks(tag, ns, nbits);
        clk_en = 1'b0;
        repeat (3) @(negedge clk);
        chk({tag, " R5 idle clock level"}, int'(sck_out), int'(ib));
        chk({tag, " R5 idle sync level"}, int'(lr_out), int'(il));
        chk({tag, " R5 idle data"}, int'(sd_out), 0);
    endtask

    task automatic slave_bit(input logic lr_norm, input bit ib, input bit il);
        sck_in = 1'b0 ^ ib;
        lr_in  = lr_norm ^ il;
        repeat (H) @(negedge clk);
    endtask

    task automatic run_slave(input string tag, input int code, input int sm1,
                             input bit ib, input bit il, input int ns, input int nbits);
        logic idle_lr;
        do_reset();
        fmt_code = 3'(code); tdm_slots_m1 = 3'(sm1);
        inv_s_bck = ib; inv_s_lr = il;
        load_samples(ns, code * 3 + 1);
        idle_lr = (code == 2 || code == 3);
        sck_in = ib; lr_in = idle_lr ^ il;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            slave_bit(idle_lr, ib, il);
            chk({tag, " R7 no data before frame"}, int'(sd_out), 0);
            sck_in = 1'b1 ^ ib;
            repeat (H) @(negedge clk);
        end
        for (int p = 0; p < nbits; p++) begin
            slave_bit(elr(p), ib, il);
            chk({tag, " R7/R2/R3 data bit"}, int'(sd_out), int'(ebit(p, ns)));
            if (p % 32 == 5) chk({tag, " R7 outputs quiet"}, int'({sck_out, lr_out}), 0);
            sck_in = 1'b1 ^ ib;
            repeat (H) @(negedge clk);
        end
        end_checks(tag, ns, nbits);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 sd_out in reset", int'(sd_out), 0);
        chk("R10 s_ready in reset", int'(s_ready), 0);
        chk("R10 underrun in reset", int'(underrun), 0);
        chk("R10 clocks in reset", int'({sck_out, lr_out}), 0);
        rst = 1'b0;
        master_mode = 1'b1; clk_en = 1'b0; inv_m_bck = 1'b1; inv_m_lr = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i % 5 == 4) begin
                chk("R5 disabled clock held", int'(sck_out), 1);
                chk("R5 disabled sync held", int'(lr_out), 1);
                chk("R5 disabled no request", int'(s_ready), 0);
            end
        end

        run_master("pcm master",        2, 0, 2, 1'b0, 1'b0, 4, 128);
        run_master("i2s master inv",    3, 0, 3, 1'b1, 1'b1, 3, 128);
        run_master("mono master",       0, 0, 1, 1'b0, 1'b0, 2, 96);
        run_master("mono lag master",   1, 0, 2, 1'b0, 1'b1, 3, 96);
        run_master("tdm4 master",       4, 3, 2, 1'b1, 1'b0, 8, 256);
        run_master("tdm8 lag master",   5, 7, 1, 1'b0, 1'b0, 5, 192);
        run_slave ("tdm3 lag slave inv",5, 2, 1'b1, 1'b1, 3, 128);
        run_slave ("pcm slave",         2, 0, 1'b0, 1'b0, 6, 128);
        run_slave ("i2s slave bck inv", 3, 0, 1'b1, 1'b0, 4, 128);
        run_slave ("mono slave lr inv", 0, 0, 1'b0, 1'b1, 2, 64);

        done = 1;
        summary();
        $finish;
    end

endmodule